// File: doc/BRIEF.md
# Shared External Interrupt Controller

This block collects 32 external interrupt lines and turns them into routed interrupt requests. Each line can be set up on its own. It can be level-sensitive or edge-sensitive, active-high or active-low, and in edge mode it can also be made to capture transitions in both directions. Software configures the block through a 32-bit register bus. Through that bus it can also enable or disable any set of lines, create or remove a captured edge event, and read back the enable vector and the pending vector.

Each line has its own route word. The route word can send the line to one of up to 64 output pins, to the non-maskable output, to an auxiliary output, or to any combination of these. An output is high while at least one enabled, pending line is routed to it. The source inputs are assumed to be synchronised to `clk` before they reach the block.

The register bus has no back-pressure. A write is taken on the rising edge of `clk` when `bus_sel` and `bus_wr` are both high. A read is combinational: while `bus_sel` is high and `bus_wr` is low, `bus_rdata` shows the addressed word, and it is zero otherwise. Offsets are byte addresses and must be word-aligned.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, the polarity, trigger, dual-edge, enable and route registers are all zero, every output is low, and every read returns zero.
- R2: A line in level mode (trigger bit 0) is pending while its input equals its polarity bit: high when polarity is 1, low when polarity is 0. The polarity register is read and written at offset 0x100.
- R3: A line in edge mode (trigger bit 1, register at 0x180) captures a rising edge when its polarity bit is 1 and a falling edge when it is 0. The capture stays pending after the input returns, until software clears it.
- R4: When a line's dual-edge bit is set (register at 0x200, read/write) and the line is in edge mode, both rising and falling transitions are captured, whatever the polarity.
- R5: A write to 0x280 with bit 31 = 1 sets the edge capture of the line numbered by bits [4:0]. A write with bit 31 = 0 clears that capture.
- R6: If an edge arrives in the same cycle as a clear command for that line, the capture stays set.
- R7: Writing 1s to 0x380 enables the matching lines, and writing 1s to 0x300 disables them. Bits written as 0 leave their lines unchanged. The enable vector reads back at 0x400, with 1 meaning enabled.
- R8: A read of 0x480 returns the pending vector ANDed with the enable vector.
- R9: Line n has a route word at 0x500 + 4*n. Bit 31 routes the line to the pin numbered by bits [5:0]. That pin is high while any enabled, pending line routed to it is present; a line that is disabled drives no pin.
- R10: Bit 30 of a route word routes the line to `nmi_out` and bit 29 routes it to `alt_out`. Each of these outputs is the OR over all enabled, pending lines that select it.
- R11: Reads of the write-only offsets (0x280, 0x300, 0x380) and of unmapped offsets return zero. A route word reads back only bits 31, 30, 29 and [5:0], with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when not reading |
| src_in | input | 32 | Synchronised interrupt source lines |
| pin_out | output | 64 | Routed interrupt pins |
| nmi_out | output | 1 | Non-maskable interrupt request |
| alt_out | output | 1 | Auxiliary interrupt request |

## Verification
The bench targets four corner cases.

- Capture polarity: it drives the opposite edge to the selected polarity. A design that ignores polarity in edge mode reports a pending line there.
- Capture latching: it returns the input to idle after an edge. A design that does not latch the capture drops the request.
- Edge against clear: it issues a clear command in the same cycle as a new edge. A design that lets the clear win loses that interrupt.
- Bus side effects: it writes zeros to the enable and disable registers and routes a disabled line. A design that treats 0 bits as commands, or routes without checking the enable, shows a wrong enable vector or a stray pin.

It also reads back the write-only and unmapped offsets, which must return zero.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  // Byte offsets of the register window
  localparam int unsigned OFS_POL  = 32'h100;
  localparam int unsigned OFS_TRIG = 32'h180;
  localparam int unsigned OFS_DUAL = 32'h200;
  localparam int unsigned OFS_EDGE = 32'h280;
  localparam int unsigned OFS_MCLR = 32'h300;
  localparam int unsigned OFS_MSET = 32'h380;
  localparam int unsigned OFS_MASK = 32'h400;
  localparam int unsigned OFS_PEND = 32'h480;
  localparam int unsigned OFS_MAP  = 32'h500;

  // Field positions that software depends on
  localparam int BIT_TO_PIN  = 31;
  localparam int BIT_TO_NMI  = 30;
  localparam int BIT_TO_ALT  = 29;
  localparam int BIT_CMD_SET = 31;
  localparam int PIN_W       = 6;

  typedef struct packed {
    logic             to_pin;
    logic             to_nmi;
    logic             to_alt;
    logic [PIN_W-1:0] pin;
  } route_t;
endpackage

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NSRC-1:0]         pend_raw,
  output logic [NSRC-1:0]         pol,
  output logic [NSRC-1:0]         trig,
  output logic [NSRC-1:0]         dual,
  output logic [NSRC-1:0]         enable,
  output route_t [NSRC-1:0]       route_q,
  output logic [NSRC-1:0]         cmd_set,
  output logic [NSRC-1:0]         cmd_clr
);
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);
  localparam logic [ADDR_W-1:0] A_DUAL = ADDR_W'(OFS_DUAL);
  localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFS_MCLR);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFS_MSET);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_MAP  = ADDR_W'(OFS_MAP);
  localparam logic [ADDR_W-1:0] A_MAPE = ADDR_W'(OFS_MAP + 4 * NSRC);

  logic               wr_en, rd_en, map_hit;
  logic [ADDR_W-1:0]  map_off;
  logic [SRC_W-1:0]   map_idx;
  logic [NSRC-1:0]    wvec;
  logic [SRC_W-1:0]   cmd_idx;
  logic               cmd_hit;

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign wvec    = bus_wdata[NSRC-1:0];
  assign map_off = bus_addr - A_MAP;
  assign map_idx = map_off[SRC_W+1:2];
  assign map_hit = (bus_addr >= A_MAP) && (bus_addr < A_MAPE) && (bus_addr[1:0] == 2'b00);

  // Edge command decode: one-hot set or clear strobe for the addressed line
  assign cmd_hit = wr_en && (bus_addr == A_EDGE);
  assign cmd_idx = bus_wdata[SRC_W-1:0];
  assign cmd_set = (cmd_hit &&  bus_wdata[BIT_CMD_SET]) ? (NSRC'(1) << cmd_idx) : '0;
  assign cmd_clr = (cmd_hit && !bus_wdata[BIT_CMD_SET]) ? (NSRC'(1) << cmd_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol    <= '0;
      trig   <= '0;
      dual   <= '0;
      enable <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_POL:   pol    <= wvec;
        A_TRIG:  trig   <= wvec;
        A_DUAL:  dual   <= wvec;
        A_MSET:  enable <= enable | wvec;
        A_MCLR:  enable <= enable & ~wvec;
        default: ;
      endcase
    end
  end

  generate
    for (genvar n = 0; n < NSRC; n++) begin : g_route
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          route_q[n] <= '0;
        end else if (wr_en && map_hit && (map_idx == SRC_W'(n))) begin
          route_q[n].to_pin <= bus_wdata[BIT_TO_PIN];
          route_q[n].to_nmi <= bus_wdata[BIT_TO_NMI];
          route_q[n].to_alt <= bus_wdata[BIT_TO_ALT];
          route_q[n].pin    <= bus_wdata[PIN_W-1:0];
        end
      end
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        A_POL:  bus_rdata[NSRC-1:0] = pol;
        A_TRIG: bus_rdata[NSRC-1:0] = trig;
        A_DUAL: bus_rdata[NSRC-1:0] = dual;
        A_MASK: bus_rdata[NSRC-1:0] = enable;
        A_PEND: bus_rdata[NSRC-1:0] = pend_raw & enable;
        default: begin
          if (map_hit) begin
            bus_rdata[BIT_TO_PIN]  = route_q[map_idx].to_pin;
            bus_rdata[BIT_TO_NMI]  = route_q[map_idx].to_nmi;
            bus_rdata[BIT_TO_ALT]  = route_q[map_idx].to_alt;
            bus_rdata[PIN_W-1:0]   = route_q[map_idx].pin;
          end
        end
      endcase
    end
  end

  // R7: written ones become enabled on the next cycle
  a_r7_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_MSET) |=> ((enable & $past(wvec)) == $past(wvec)));
  // R7: zeros in a set-mask write leave other lines untouched
  a_r7_zero_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_MSET) |=> ((enable & ~$past(wvec)) == ($past(enable) & ~$past(wvec))));
  // R7: written ones in a clear-mask write become disabled
  a_r7_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_MCLR) |=> ((enable & $past(wvec)) == '0));
  // R5: at most one command strobe per cycle
  a_r5_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_set, cmd_clr}));
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] trig,
  input  logic [NSRC-1:0] dual,
  input  logic [NSRC-1:0] cmd_set,
  input  logic [NSRC-1:0] cmd_clr,
  output logic [NSRC-1:0] pend_raw
);
  logic [NSRC-1:0] prev_q, cap_q, edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_in;
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_line
      logic rise, fall, sel_edge, lvl_act;
      assign rise     = src_in[i] & ~prev_q[i];
      assign fall     = ~src_in[i] & prev_q[i];
      assign sel_edge = dual[i] ? (rise | fall) : (pol[i] ? rise : fall);
      assign edge_hit[i] = trig[i] & sel_edge;
      assign lvl_act  = ~(src_in[i] ^ pol[i]);

      // A new edge takes priority over a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cap_q[i] <= 1'b0;
        else if (edge_hit[i] | cmd_set[i]) cap_q[i] <= 1'b1;
        else if (cmd_clr[i])               cap_q[i] <= 1'b0;
      end

      assign pend_raw[i] = trig[i] ? cap_q[i] : lvl_act;
    end
  endgenerate

  // R5: a set command leaves the capture set
  a_r5_set_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_set != '0) |=> ((cap_q & $past(cmd_set)) == $past(cmd_set)));
  // R5: a clear command with no competing edge empties the capture
  a_r5_clr_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_clr & ~edge_hit) != '0) |=> ((cap_q & $past(cmd_clr & ~edge_hit)) == '0));
  // R6: edge wins over a simultaneous clear
  a_r6_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & cmd_clr) != '0) |=> ((cap_q & $past(edge_hit & cmd_clr)) == $past(edge_hit & cmd_clr)));
  // R3: a capture holds until a clear command
  a_r3_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_q & ~cmd_clr) != '0) |=> ((cap_q & $past(cap_q & ~cmd_clr)) == $past(cap_q & ~cmd_clr)));
endmodule

// File: rtl/xirq_route.sv
module xirq_route
  import xirq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NPINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     pend_raw,
  input  logic [NSRC-1:0]     enable,
  input  route_t [NSRC-1:0]   route_q,
  output logic [NPINS-1:0]    pin_out,
  output logic                nmi_out,
  output logic                alt_out
);
  logic [NSRC-1:0] hot;
  assign hot = pend_raw & enable;

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NSRC; s++)
          hit = hit | (hot[s] & route_q[s].to_pin & (route_q[s].pin == PIN_W'(p)));
      end
      assign pin_out[p] = hit;
    end
  endgenerate

  always_comb begin
    nmi_out = 1'b0;
    alt_out = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      nmi_out = nmi_out | (hot[s] & route_q[s].to_nmi);
      alt_out = alt_out | (hot[s] & route_q[s].to_alt);
    end
  end

  // R9: with no enabled pending line, nothing is driven
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (hot == '0) |-> (pin_out == '0 && !nmi_out && !alt_out));
  // R10: nmi and aux outputs only follow enabled lines
  a_r10_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> (!nmi_out && !alt_out));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NPINS  = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic [NPINS-1:0]  pin_out,
  output logic              nmi_out,
  output logic              alt_out
);
  logic [NSRC-1:0] pol, trig, dual, enable, cmd_set, cmd_clr, pend_raw;
  route_t [NSRC-1:0] route_q;

  xirq_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_raw(pend_raw), .pol(pol), .trig(trig), .dual(dual),
    .enable(enable), .route_q(route_q), .cmd_set(cmd_set), .cmd_clr(cmd_clr)
  );

  xirq_detect #(.NSRC(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .pol(pol), .trig(trig),
    .dual(dual), .cmd_set(cmd_set), .cmd_clr(cmd_clr), .pend_raw(pend_raw)
  );

  xirq_route #(.NSRC(NSRC), .NPINS(NPINS)) u_route (
    .clk(clk), .rst_n(rst_n), .pend_raw(pend_raw), .enable(enable),
    .route_q(route_q), .pin_out(pin_out), .nmi_out(nmi_out), .alt_out(alt_out)
  );
endmodule

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, chk_out = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] src_in = '0, cur_src = '0;
  logic [63:0] pin_out;
  logic        nmi_out, alt_out;
  int          nchk = 0, nerr = 0;

  typedef struct {
    bit          is_rd;
    logic [31:0] d;
    logic [63:0] pins;
    bit          nmi, alt;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  xirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .pin_out(pin_out), .nmi_out(nmi_out), .alt_out(alt_out)
  );

  // Driver: every operation occupies exactly one cycle, driven after the edge
  task automatic cyc(bit sel, bit wr, logic [11:0] a, logic [31:0] d, logic [31:0] s, bit chk);
    @(posedge clk); #1;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; src_in = s; chk_out = chk;
  endtask
  task automatic wr(logic [11:0] a, logic [31:0] d);
    cyc(1, 1, a, d, cur_src, 0);
  endtask
  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    exp_t x; x.is_rd = 1; x.d = e; x.pins = '0; x.nmi = 0; x.alt = 0; x.tag = tag;
    sb.push_back(x);
    cyc(1, 0, a, 0, cur_src, 0);
  endtask
  task automatic setsrc(logic [31:0] s);
    cur_src = s;
    cyc(0, 0, 0, 0, s, 0);
  endtask
  task automatic outs(logic [63:0] p, bit n, bit a, string tag);
    exp_t x; x.is_rd = 0; x.d = '0; x.pins = p; x.nmi = n; x.alt = a; x.tag = tag;
    sb.push_back(x);
    cyc(0, 0, 0, 0, cur_src, 1);
  endtask

  // Monitor: pops the scoreboard whenever a read or output check is in flight
  always @(negedge clk) begin
    if (rst_n && ((bus_sel && !bus_wr) || chk_out)) begin
      if (sb.size() == 0) begin
        nerr++;
        $display("FAIL monitor: sample with empty scoreboard, rdata=%h", bus_rdata);
      end else begin
        exp_t x;
        x = sb.pop_front();
        nchk++;
        if (x.is_rd) begin
          if (bus_rdata !== x.d) begin
            nerr++;
            $display("FAIL %s: addr=%h actual=%h expected=%h", x.tag, bus_addr, bus_rdata, x.d);
          end
        end else if (pin_out !== x.pins || nmi_out !== x.nmi || alt_out !== x.alt) begin
          nerr++;
          $display("FAIL %s: actual pins=%h nmi=%b alt=%b expected pins=%h nmi=%b alt=%b",
                   x.tag, pin_out, nmi_out, alt_out, x.pins, x.nmi, x.alt);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    nerr++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(12'h100, 32'h0, "R1 polarity after reset");
    rd(12'h180, 32'h0, "R1 trigger after reset");
    rd(12'h400, 32'h0, "R1 enable after reset");
    rd(12'h480, 32'h0, "R1 pending after reset");
    rd(12'h500, 32'h0, "R1 route after reset");
    outs(64'h0, 0, 0, "R1 outputs after reset");

    // R11 write-only and unmapped reads
    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h300, 32'h0, "R11 clear-mask reads zero");
    rd(12'h380, 32'h0, "R11 set-mask reads zero");
    rd(12'h280, 32'h0, "R11 edge command reads zero");
    rd(12'h580, 32'h0, "R11 unmapped past routes");
    rd(12'h004, 32'h0, "R11 unmapped low offset");

    // R7 enable set and clear
    wr(12'h380, 32'h0000_00F0);
    rd(12'h400, 32'h0000_00F0, "R7 set mask");
    wr(12'h380, 32'h0000_0003);
    rd(12'h400, 32'h0000_00F3, "R7 set mask zeros keep");
    wr(12'h300, 32'h0000_0010);
    rd(12'h400, 32'h0000_00E3, "R7 clear mask");
    wr(12'h300, 32'h0);
    rd(12'h400, 32'h0000_00E3, "R7 clear with zeros no effect");

    // R2 / R8 level mode and masked pending
    wr(12'h100, 32'h0000_0001);
    setsrc(32'h1);
    rd(12'h480, 32'h0000_00E3, "R2 R8 level both polarities");
    setsrc(32'h0);
    rd(12'h480, 32'h0000_00E2, "R2 active-high line released");
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h480, 32'h0, "R2 all active-high idle");
    rd(12'h100, 32'hFFFF_FFFF, "R2 polarity readback");

    // R9 / R11 route words
    wr(12'h500, 32'h8000_0005);
    rd(12'h500, 32'h8000_0005, "R9 route readback");
    wr(12'h504, 32'hFFFF_FFFF);
    rd(12'h504, 32'hE000_003F, "R11 route defined bits only");
    wr(12'h504, 32'h4000_0000);
    setsrc(32'h1);
    outs(64'h20, 0, 0, "R9 line0 to pin5");
    rd(12'h480, 32'h1, "R8 pending line0");

    // R10 nmi and aux
    wr(12'h514, 32'h2000_0000);
    setsrc(32'h22);
    outs(64'h0, 1, 1, "R10 nmi and aux");

    // R9 disabled line drives nothing, then enabled
    wr(12'h508, 32'h8000_003F);
    setsrc(32'h4);
    outs(64'h0, 0, 0, "R9 disabled line silent");
    wr(12'h380, 32'h0000_0004);
    outs(64'h8000_0000_0000_0000, 0, 0, "R9 enabled line to pin63");

    // R9 shared pin
    wr(12'h518, 32'h8000_003F);
    wr(12'h300, 32'h0000_0004);
    setsrc(32'h40);
    outs(64'h8000_0000_0000_0000, 0, 0, "R9 second line shares pin63");
    setsrc(32'h0);
    outs(64'h0, 0, 0, "R9 all idle");

    // R3 rising capture holds
    wr(12'h51C, 32'h8000_000A);
    wr(12'h180, 32'h0000_0080);
    setsrc(32'h80);
    rd(12'h480, 32'h80, "R3 rising captured");
    setsrc(32'h0);
    outs(64'h400, 0, 0, "R3 capture holds after release");
    wr(12'h280, 32'h0000_0007);
    outs(64'h0, 0, 0, "R5 clear command drops pin");

    // R3 falling polarity
    wr(12'h100, 32'hFFFF_FF7F);
    setsrc(32'h80);
    rd(12'h480, 32'h0, "R3 rising ignored on falling polarity");
    setsrc(32'h0);
    rd(12'h480, 32'h80, "R3 falling captured");
    wr(12'h280, 32'h0000_0007);
    rd(12'h480, 32'h0, "R5 clear falling capture");

    // R4 dual edge
    wr(12'h200, 32'h0000_0080);
    rd(12'h200, 32'h0000_0080, "R4 dual readback");
    setsrc(32'h80);
    rd(12'h480, 32'h80, "R4 rising captured in dual mode");
    wr(12'h280, 32'h0000_0007);
    rd(12'h480, 32'h0, "R4 cleared");
    setsrc(32'h0);
    rd(12'h480, 32'h80, "R4 falling captured in dual mode");
    wr(12'h280, 32'h0000_0007);
    rd(12'h480, 32'h0, "R4 cleared again");

    // R5 software set
    wr(12'h280, 32'h8000_0007);
    rd(12'h480, 32'h80, "R5 set command");
    outs(64'h400, 0, 0, "R5 set command routes pin10");
    wr(12'h280, 32'h0000_0007);
    rd(12'h480, 32'h0, "R5 clear after set");

    // R6 edge beats clear in the same cycle
    cur_src = 32'h80;
    cyc(1, 1, 12'h280, 32'h0000_0007, 32'h80, 0);
    rd(12'h480, 32'h80, "R6 edge wins over clear");

    cyc(0, 0, 0, 0, cur_src, 0);
    cyc(0, 0, 0, 0, cur_src, 0);
    if (sb.size() != 0) begin
      nerr++;
      $display("FAIL scoreboard: actual=%0d left expected=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule